// File: doc/BRIEF.md
# Command-to-APB Requester Bridge

The bridge takes single read or write commands from an upstream valid/ready port and runs each one as a two-phase APB transfer. Every command carries an address, a write flag, write data and byte strobes. The bridge drives a SETUP cycle and then an ACCESS cycle. It waits through any number of PREADY-low cycles. It returns read data and an error flag on a response valid/ready port.

Only one command is in flight at a time. The response is offered in the cycle the APB transfer completes. If the upstream side takes it in that cycle and has another command waiting, the next cycle is already the SETUP of the following transfer. PSEL then stays asserted when the peripheral is unchanged. If the response is not taken, it is captured and held until it is. A field of the address selects one of several peripheral select lines.

Top module: `cmd_apb_bridge`

## Requirements
- R1: An accepted command gives one SETUP cycle and then ACCESS. In SETUP the selected PSEL is high and PENABLE is low. In the following cycle PENABLE is high and the same PSEL is held. PADDR, PWRITE and PWDATA equal the command's address, write flag and data in both phases.
- R2: While PENABLE is high and PREADY is low, the bridge stays in ACCESS. PSEL, PENABLE, PADDR, PWRITE, PWDATA and PSTRB do not change, for any number of wait cycles.
- R3: Address bits [13:12] of value k assert psel_o[k] and no other select line. At most one select line is ever high.
- R4: After reset, and whenever no command is in flight, every select line and PENABLE are low, cmd_ready_o is high and rsp_valid_o is low.
- R5: For writes, PSTRB equals the command strobes. For reads, PSTRB is zero.
- R6: For a read, rsp_rdata_o equals PRDATA as seen in the cycle where a select line, PENABLE and PREADY are all high. rsp_err_o equals PSLVERR from that same cycle. Values seen in wait cycles have no effect. For a write, rsp_rdata_o is zero.
- R7: rsp_valid_o first rises in the completing cycle. While it is high and rsp_ready_i is low, it stays high, and rsp_rdata_o and rsp_err_o hold their values.
- R8: cmd_ready_o is low from the cycle after a command is accepted until the cycle in which its response is taken. It is high in that response-handshake cycle.
- R9: If a command is accepted in the cycle of a completion, the next cycle is a SETUP cycle. For the same target, the select line stays high with no gap. For a new target, the old line drops as the new one rises.
- R10: PENABLE is low in the cycle after every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command taken when both are high |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_wdata_i | input | DATA_W | Write data |
| cmd_strb_i | input | DATA_W/8 | Write byte strobes |
| rsp_valid_o | output | 1 | Response offered |
| rsp_ready_i | input | 1 | Response taken when both are high |
| rsp_rdata_o | output | DATA_W | Read data (zero for writes) |
| rsp_err_o | output | 1 | Error flag of the completed transfer |
| psel_o | output | N_TGT | One select line per peripheral |
| penable_o | output | 1 | ACCESS phase marker |
| paddr_o | output | ADDR_W | APB address |
| pwrite_o | output | 1 | APB direction |
| pwdata_o | output | DATA_W | APB write data |
| pstrb_o | output | DATA_W/8 | APB write strobes |
| prdata_i | input | DATA_W | APB read data |
| pready_i | input | 1 | APB ready |
| pslverr_i | input | 1 | APB error |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 32-bit data path, four select lines and the select field at bit 12. Its peripheral model derives the wait count (0 to 31) and the error flag from low address bits. This brings zero, single and long wait runs within reach on all four targets. In wait cycles the model drives inverted data and error, so a response sampled outside the completing cycle is exposed. Two upstream patterns are used. With the response port always ready, back-to-back same-target and target-switching sequences are reached. With the response port stalled pseudo-randomly, the captured-response hold path is exercised.

// File: rtl/cab_pkg.sv
`timescale 1ns/1ps
package cab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } cab_state_e;
endpackage

// File: rtl/cab_decode.sv
`timescale 1ns/1ps
module cab_decode #(
  parameter int N_TGT = 4,
  localparam int SEL_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [SEL_W-1:0] field_i,
  input  logic             active_i,
  output logic [N_TGT-1:0] sel_o
);
  for (genvar t = 0; t < N_TGT; t++) begin : g_sel
    assign sel_o[t] = active_i && (field_i == SEL_W'(t));
  end
endmodule

// File: rtl/cab_fsm.sv
`timescale 1ns/1ps
module cab_fsm
  import cab_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       pready_i,
  input  logic       rsp_ready_i,
  output cab_state_e state_o,
  output logic       cmd_ready_o,
  output logic       accept_o,
  output logic       rsp_valid_o,
  output logic       capture_o
);
  cab_state_e state_q, state_d;
  logic       complete;

  assign complete    = (state_q == ST_ACCESS) && pready_i;
  // response slot frees in the handshake cycle, so a new command may enter there
  assign cmd_ready_o = (state_q == ST_IDLE)
                     || (complete && rsp_ready_i)
                     || ((state_q == ST_HOLD) && rsp_ready_i);
  assign accept_o    = cmd_valid_i && cmd_ready_o;
  assign rsp_valid_o = complete || (state_q == ST_HOLD);
  assign capture_o   = complete && !rsp_ready_i;
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: begin
        if (pready_i) begin
          if (!rsp_ready_i)  state_d = ST_HOLD;
          else if (accept_o) state_d = ST_SETUP;
          else               state_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (rsp_ready_i) state_d = accept_o ? ST_SETUP : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r9_accept_to_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (state_q == ST_SETUP));
  a_r8_busy_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> !cmd_ready_o);
endmodule

// File: rtl/cab_rsp_hold.sv
`timescale 1ns/1ps
module cab_rsp_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              hold_i,
  input  logic              is_write_i,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pslverr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic [DATA_W-1:0] rdata_q, rdata_live;
  logic              err_q;

  assign rdata_live = is_write_i ? '0 : prdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (capture_i) begin
      rdata_q <= rdata_live;
      err_q   <= pslverr_i;
    end
  end

  assign rdata_o = hold_i ? rdata_q : rdata_live;
  assign err_o   = hold_i ? err_q   : pslverr_i;

  a_r6_hold_follows_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> hold_i);
endmodule

// File: rtl/cmd_apb_bridge.sv
`timescale 1ns/1ps
module cmd_apb_bridge
  import cab_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int N_TGT   = 4,
  parameter int SEL_LSB = 12,
  localparam int STRB_W = DATA_W / 8,
  localparam int SEL_W  = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_write_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic [STRB_W-1:0] cmd_strb_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [N_TGT-1:0]  psel_o,
  output logic              penable_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              pwrite_o,
  output logic [DATA_W-1:0] pwdata_o,
  output logic [STRB_W-1:0] pstrb_o,
  input  logic [DATA_W-1:0] prdata_i,
  input  logic              pready_i,
  input  logic              pslverr_i
);
  cab_state_e        state;
  logic              accept, capture, on_bus;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STRB_W-1:0] strb_q;

  cab_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .pready_i    (pready_i),
    .rsp_ready_i (rsp_ready_i),
    .state_o     (state),
    .cmd_ready_o (cmd_ready_o),
    .accept_o    (accept),
    .rsp_valid_o (rsp_valid_o),
    .capture_o   (capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      strb_q  <= '0;
    end else if (accept) begin
      addr_q  <= cmd_addr_i;
      write_q <= cmd_write_i;
      wdata_q <= cmd_wdata_i;
      strb_q  <= cmd_write_i ? cmd_strb_i : '0;
    end
  end

  assign on_bus    = (state == ST_SETUP) || (state == ST_ACCESS);
  assign penable_o = (state == ST_ACCESS);
  assign paddr_o   = addr_q;
  assign pwrite_o  = write_q;
  assign pwdata_o  = wdata_q;
  assign pstrb_o   = strb_q;

  cab_decode #(.N_TGT(N_TGT)) i_decode (
    .field_i  (addr_q[SEL_LSB +: SEL_W]),
    .active_i (on_bus),
    .sel_o    (psel_o)
  );

  cab_rsp_hold #(.DATA_W(DATA_W)) i_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .hold_i     (state == ST_HOLD),
    .is_write_i (write_q),
    .prdata_i   (prdata_i),
    .pslverr_i  (pslverr_i),
    .rdata_o    (rsp_rdata_o),
    .err_o      (rsp_err_o)
  );

  a_r1_setup_to_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|psel_o) && !penable_o) |=> (penable_o && $stable(psel_o)));
  a_r2_wait_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && !pready_i) |=> (penable_o && $stable(psel_o) && $stable(paddr_o)
      && $stable(pwrite_o) && $stable(pwdata_o) && $stable(pstrb_o)));
  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(psel_o));
  a_r4_enable_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> ($countones(psel_o) == 1));
  a_r5_read_no_strb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|psel_o) && !pwrite_o) |-> (pstrb_o == '0));
  a_r7_rsp_at_completion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && pready_i) |-> rsp_valid_o);
  a_r7_rsp_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)
      && $stable(rsp_err_o)));
  a_r8_wait_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && !pready_i) |-> !cmd_ready_o);
  a_r10_enable_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && pready_i) |=> !penable_o);
endmodule

// File: tb/test_cmd_apb_bridge.sv
`timescale 1ns/1ps
module test_cmd_apb_bridge;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int N_TGT  = 4;
  localparam int STRB_W = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DATA_W-1:0] data;
    logic [STRB_W-1:0] strb;
  } apb_item_t;
  typedef struct packed {
    logic [DATA_W-1:0] rdata;
    logic              err;
  } rsp_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic [STRB_W-1:0] cmd_strb = '0;
  logic cmd_ready, rsp_valid, rsp_err, penable, pwrite;
  logic [DATA_W-1:0] rsp_rdata, pwdata;
  logic [N_TGT-1:0] psel;
  logic [ADDR_W-1:0] paddr;
  logic [STRB_W-1:0] pstrb;
  logic [DATA_W-1:0] prdata = '0;
  logic pready = 1'b0, pslverr = 1'b0;

  always #2.5 clk = ~clk;

  cmd_apb_bridge i_cmd_apb_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_addr_i(cmd_addr),
    .cmd_write_i(cmd_write), .cmd_wdata_i(cmd_wdata), .cmd_strb_i(cmd_strb),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .psel_o(psel), .penable_o(penable), .paddr_o(paddr),
    .pwrite_o(pwrite), .pwdata_o(pwdata), .pstrb_o(pstrb), .prdata_i(prdata),
    .pready_i(pready), .pslverr_i(pslverr)
  );

  int n_chk = 0, n_bad = 0;
  apb_item_t apb_q[$];
  rsp_item_t rsp_q[$];
  bit rsp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA7;
  int acc_cnt = 0;

  function automatic logic [DATA_W-1:0] rd_val(logic [ADDR_W-1:0] a);
    return 32'hC0DE_0000 ^ {16'h0, a};
  endfunction
  function automatic int wait_of(logic [ADDR_W-1:0] a);
    return int'(a[4:0]);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // peripheral model: wait count and error from address, wrong values in wait cycles
  always @(posedge clk) begin
    #1;
    if ((|psel) && penable) begin
      if (acc_cnt == wait_of(paddr)) pready = 1'b1;
      else begin pready = 1'b0; acc_cnt++; end
      prdata  = pready ? rd_val(paddr) : ~rd_val(paddr);
      pslverr = pready ? paddr[5] : ~paddr[5];
    end else begin
      pready = 1'b0; acc_cnt = 0; prdata = 32'hDEAD_BEEF; pslverr = 1'b1;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = rsp_mode ? lfsr[0] : 1'b1;
  end

  // monitors
  bit busy = 0, p_setup = 0, p_wait = 0, p_cmpl = 0, p_b2b = 0, p_stall = 0;
  logic [N_TGT-1:0] p_sel;
  logic [57:0] snap;
  logic [DATA_W-1:0] s_rd;
  logic s_err;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit setup_now = (|psel) && !penable;
      automatic bit cmpl_now  = penable && pready;
      automatic bit rsp_hs    = rsp_valid && rsp_ready;
      automatic bit acc       = cmd_valid && cmd_ready;
      if (p_setup) chk(penable && psel == p_sel, "R1", "access follows setup", {psel, penable}, {p_sel, 1'b1});
      if (p_wait) chk({psel, penable, paddr, pwrite, pwdata, pstrb} == snap, "R2", "frozen in wait",
                      {psel, penable, paddr, pwrite, pwdata, pstrb}, snap);
      if (p_cmpl) chk(!penable, "R10", "penable after completion", penable, 0);
      if (p_b2b) begin
        chk(setup_now, "R9", "setup right after completion", {psel, penable}, {p_sel, 1'b0});
        if (psel == p_sel) chk(p_sel != 0, "R9", "same target kept", psel, p_sel);
        else chk((psel & p_sel) == 0, "R9", "old select dropped", psel & p_sel, 0);
      end
      if (setup_now) begin
        if (apb_q.size() == 0) chk(0, "R1", "unexpected setup", paddr, 0);
        else begin
          automatic apb_item_t e = apb_q.pop_front();
          chk(paddr == e.addr && pwrite == e.wr && pwdata == e.data, "R1", "setup fields",
              {paddr, pwrite, pwdata}, {e.addr, e.wr, e.data});
          chk(pstrb == e.strb, "R5", "pstrb", pstrb, e.strb);
          chk(psel == N_TGT'(1 << e.addr[13:12]), "R3", "select decode", psel, N_TGT'(1 << e.addr[13:12]));
        end
      end
      if (!busy) chk(psel == 0 && !penable && cmd_ready && !rsp_valid, "R4", "idle outputs",
                     {psel, penable, cmd_ready, rsp_valid}, {4'h0, 3'b010});
      if (busy) chk(cmd_ready == rsp_hs, "R8", "ready only at response handshake", cmd_ready, rsp_hs);
      if (p_stall) chk(rsp_valid && rsp_rdata == s_rd && rsp_err == s_err, "R7", "response held",
                       {rsp_valid, rsp_rdata, rsp_err}, {1'b1, s_rd, s_err});
      if (rsp_valid && !p_stall) chk(cmpl_now, "R7", "response rises at completion", cmpl_now, 1);
      if (rsp_hs) begin
        if (rsp_q.size() == 0) chk(0, "R6", "unexpected response", rsp_rdata, 0);
        else begin
          automatic rsp_item_t r = rsp_q.pop_front();
          chk(rsp_rdata == r.rdata && rsp_err == r.err, "R6", "response data/error",
              {rsp_rdata, rsp_err}, {r.rdata, r.err});
        end
      end
      busy    = (busy && !rsp_hs) || acc;
      p_setup = setup_now;
      p_wait  = penable && !pready;
      p_cmpl  = cmpl_now;
      p_b2b   = cmpl_now && acc;
      p_stall = rsp_valid && !rsp_ready;
      p_sel   = psel;
      snap    = {psel, penable, paddr, pwrite, pwdata, pstrb};
      s_rd    = rsp_rdata;
      s_err   = rsp_err;
    end
  end

  task automatic send(input logic [ADDR_W-1:0] a, input logic w, input logic [DATA_W-1:0] d,
                      input logic [STRB_W-1:0] s);
    apb_q.push_back('{a, w, d, w ? s : '0});
    rsp_q.push_back('{w ? '0 : rd_val(a), a[5]});
    cmd_valid = 1'b1; cmd_addr = a; cmd_write = w; cmd_wdata = d; cmd_strb = s;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R4: reset state
    chk(psel == 0 && !penable && !rsp_valid && cmd_ready, "R4", "reset outputs",
        {psel, penable, rsp_valid, cmd_ready}, {4'h0, 3'b001});
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // writes to every target, waits 0,3,6,9 (R1 R3 R5)
    for (int t = 0; t < 4; t++)
      send(16'(t << 12) | 16'(t * 3), 1'b1, 32'h1111_0000 * (t + 1), 4'b0001 << t | 4'b1000);
    // reads: long waits and error responses (R2 R6)
    send(16'h1000, 1'b0, 32'h0, 4'hF);
    send(16'h2001, 1'b0, 32'h0, 4'hF);
    send(16'h3027, 1'b0, 32'h0, 4'hF);
    send(16'h0019, 1'b0, 32'h0, 4'h0);
    send(16'h201F, 1'b1, 32'hCAFE_F00D, 4'b0110);
    repeat (5) begin @(posedge clk); #1; end
    // back-to-back, same and switching targets (R9)
    send(16'h2002, 1'b0, 32'h0, 4'hF);
    send(16'h2000, 1'b1, 32'hA5A5_5A5A, 4'hF);
    send(16'h2021, 1'b0, 32'h0, 4'hF);
    send(16'h0000, 1'b0, 32'h0, 4'hF);
    send(16'h3004, 1'b1, 32'h0BAD_CAFE, 4'b0011);
    send(16'h3000, 1'b0, 32'h0, 4'hF);
    while (rsp_q.size() != 0) @(posedge clk);
    #1;
    // stalled response port (R7 R8)
    rsp_mode = 1'b1;
    for (int i = 0; i < 24; i++)
      send(16'((i % 4) << 12) | 16'((i * 7) % 64), i[0], 32'h9000_0000 + i, 4'(i));
    while (rsp_q.size() != 0 || rsp_valid) @(posedge clk);
    rsp_mode = 1'b0;
    repeat (5) begin @(posedge clk); #1; end
    chk(apb_q.size() == 0, "R1", "all transfers seen", apb_q.size(), 0);
    finish_run();
  end
endmodule